// File: doc/BRIEF.md
# Split-Transfer Scheduler for a Dual-Port Video RAM

This block runs on the input-video pixel clock. It decides when the random port of a dual-port video RAM should issue a split-register read transfer. The goal is that the serial output port, which runs on its own clock and feeds the panel, always has the next line loaded before it needs it. The serial side reports which half of its split shift register is being shifted out. That flag arrives asynchronously, so the block synchronizes it first.

Once per input line, the surrounding timing logic presents a candidate point, for example on entry into horizontal blanking. A transfer is requested only when the synchronized half flag has changed since the last transfer was issued. This means each half-register toggle gets at most one transfer, and no timer is needed. The synchronizer delay keeps a transfer away from the moment just after the serial side switches halves. The flag comparison keeps a second transfer from landing later in the same panel line.

Each stored line is exactly one half of a RAM row. The block therefore keeps a line index whose low bit is the half select and whose upper bits are the row. A frame-start pulse loads that index past the vertical back-porch lines, so those lines are never transferred. Transfers stop once the last active line has been sent.

Top module: `vrt_split_xfer_sched`

## Requirements
- R1: After reset, `xfer_req` is 0, `xfer_row` and `xfer_half` are 0, and the captured flag is 0. No transfer is requested until the first `frame_start` pulse has been seen.
- R2: `xfer_req` is a single-cycle pulse. It goes high only in the clock cycle right after a rising edge at which `line_mark` was sampled high.
- R3: At a candidate point (armed, `line_mark` high, `frame_start` low, frame not finished), a transfer is requested exactly when the synchronized half flag differs from the captured flag.
- R4: The captured flag takes the synchronized flag's value at the edge that issues a transfer. A later candidate point with no flag change in between requests nothing.
- R5: A change of `half_flag_async` is first used by a `line_mark` sampled at the (SYNC_STAGES+1)-th rising edge after the change. Marks sampled at earlier edges still see the old flag value.
- R6: While `xfer_req` is high, {`xfer_row`, `xfer_half`} holds the index of the line being transferred, and `xfer_half` is the index's low bit. Each transfer advances the index by one.
- R7: `frame_start` sets the next line index to SKIP_LINES and arms the block. A `line_mark` sampled in the same cycle as `frame_start` requests nothing. `frame_start` does not change the captured flag.
- R8: Once the line index reaches SKIP_LINES+ACTIVE_LINES, no further transfer is requested until the next `frame_start`, whatever the flag and marks do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-video pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at end of input vertical sync |
| line_mark | input | 1 | One-cycle pulse at the per-line candidate point |
| half_flag_async | input | 1 | Serial-port half-active flag, asynchronous |
| xfer_req | output | 1 | One-cycle split-transfer request |
| xfer_row | output | ROW_W | RAM row of the line to transfer |
| xfer_half | output | 1 | Half of the row (and of the serial register) to load |

## Verification
The bench builds the block with SYNC_STAGES=2, ROW_W=5, SKIP_LINES=4 and ACTIVE_LINES=6. With these values, a frame needs only six transfers to run out, so the end-of-frame stop, the preload past the skipped lines and the odd/even half alternation all come up many times among a few hundred candidate points. The two-stage synchronizer lets the bench step candidate marks edge by edge across the flag-visibility boundary.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

  // Index just past the last line that may be transferred in a frame.
  function automatic int unsigned stop_index(int unsigned skip_lines,
                                             int unsigned active_lines);
    return skip_lines + active_lines;
  endfunction

  // Number of bits needed to hold an index up to and including n.
  function automatic int unsigned index_bits(int unsigned n);
    int unsigned b;
    b = 1;
    while ((1 << b) <= n) b++;
    return b;
  endfunction

endpackage

// File: rtl/vrt_flag_sync.sv
module vrt_flag_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb stage_d[i] = d_async;
      end else begin : g_next
        always_comb stage_d[i] = stage_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/vrt_xfer_gate.sv
module vrt_xfer_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic line_mark,
  input  logic frame_start,
  input  logic flag_s,
  input  logic frame_done,
  output logic issue,
  output logic req_q,
  output logic last_q
);
  logic armed_q, armed_d;
  logic last_d;
  logic req_d;

  // Candidate point decision: armed, not pre-empted, flag moved.
  always_comb begin
    issue  = armed_q && line_mark && !frame_start && !frame_done
             && (flag_s != last_q);
    armed_d = armed_q | frame_start;
    last_d  = issue ? flag_s : last_q;
    req_d   = issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      last_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      last_q  <= last_d;
      req_q   <= req_d;
    end
  end
endmodule

// File: rtl/vrt_line_ptr.sv
module vrt_line_ptr #(
  parameter int unsigned IDX_W        = 6,
  parameter int unsigned SKIP_LINES   = 4,
  parameter int unsigned ACTIVE_LINES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  output logic [IDX_W-1:0] addr_o,
  output logic             done_o
);
  import vrt_pkg::*;

  localparam logic [IDX_W-1:0] START_IDX = IDX_W'(SKIP_LINES);
  localparam logic [IDX_W-1:0] STOP_IDX  = IDX_W'(stop_index(SKIP_LINES, ACTIVE_LINES));

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] addr_q, addr_d;

  always_comb begin
    idx_d  = idx_q;
    addr_d = addr_q;
    if (load) begin
      idx_d = START_IDX;
    end else if (adv) begin
      addr_d = idx_q;
      idx_d  = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      addr_q <= '0;
    end else begin
      idx_q  <= idx_d;
      addr_q <= addr_d;
    end
  end

  assign done_o = (idx_q >= STOP_IDX);
  assign addr_o = addr_q;
endmodule

// File: rtl/vrt_split_xfer_sched.sv
module vrt_split_xfer_sched #(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned ROW_W        = 9,
  parameter int unsigned SKIP_LINES   = 64,
  parameter int unsigned ACTIVE_LINES = 768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             line_mark,
  input  logic             half_flag_async,
  output logic             xfer_req,
  output logic [ROW_W-1:0] xfer_row,
  output logic             xfer_half
);
  import vrt_pkg::*;

  localparam int unsigned IDX_W = ROW_W + 1;

  initial begin
    if (index_bits(stop_index(SKIP_LINES, ACTIVE_LINES)) > IDX_W)
      $error("line index does not fit in ROW_W+1 bits");
    if (SYNC_STAGES < 2)
      $error("SYNC_STAGES must be at least 2");
  end

  logic             flag_s;
  logic             issue;
  logic             last_flag_q;
  logic             frame_done;
  logic [IDX_W-1:0] addr;

  vrt_flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (half_flag_async),
    .q_sync  (flag_s)
  );

  vrt_xfer_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_mark   (line_mark),
    .frame_start (frame_start),
    .flag_s      (flag_s),
    .frame_done  (frame_done),
    .issue       (issue),
    .req_q       (xfer_req),
    .last_q      (last_flag_q)
  );

  vrt_line_ptr #(
    .IDX_W        (IDX_W),
    .SKIP_LINES   (SKIP_LINES),
    .ACTIVE_LINES (ACTIVE_LINES)
  ) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (frame_start),
    .adv    (issue),
    .addr_o (addr),
    .done_o (frame_done)
  );

  assign xfer_row  = addr[IDX_W-1:1];
  assign xfer_half = addr[0];
endmodule

// File: rtl/vrt_split_xfer_sched_chk.sv
module vrt_split_xfer_sched_chk #(
  parameter int unsigned ROW_W        = 9,
  parameter int unsigned SKIP_LINES   = 64,
  parameter int unsigned ACTIVE_LINES = 768
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             line_mark,
  input logic             xfer_req,
  input logic [ROW_W-1:0] xfer_row,
  input logic             xfer_half,
  input logic             flag_s,
  input logic             last_flag
);
  localparam int unsigned IDX_W = ROW_W + 1;
  localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(SKIP_LINES);
  localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(SKIP_LINES + ACTIVE_LINES);

  logic [IDX_W-1:0] idx;
  assign idx = {xfer_row, xfer_half};

  a_r2_needs_mark: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> $past(line_mark));

  a_r3_flag_differs: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> ($past(flag_s) != $past(last_flag)));

  a_r4_capture_moves: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (last_flag != $past(last_flag)));

  a_r6_index_window: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (idx >= LO_IDX && idx < HI_IDX));

  a_r7_frame_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) |-> !xfer_req);
endmodule

bind vrt_split_xfer_sched vrt_split_xfer_sched_chk #(
  .ROW_W        (ROW_W),
  .SKIP_LINES   (SKIP_LINES),
  .ACTIVE_LINES (ACTIVE_LINES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .line_mark   (line_mark),
  .xfer_req    (xfer_req),
  .xfer_row    (xfer_row),
  .xfer_half   (xfer_half),
  .flag_s      (flag_s),
  .last_flag   (last_flag_q)
);

// File: tb/vrt_split_xfer_sched_tb.sv
module vrt_split_xfer_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC  = 2;
  localparam int ROWW  = 5;
  localparam int SKIP  = 4;
  localparam int ACT   = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic frame_start, line_mark, qsf;
  logic xfer_req;
  logic [ROWW-1:0] xfer_row;
  logic xfer_half;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model
  bit m_armed;
  bit m_last;
  int m_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  vrt_split_xfer_sched #(
    .SYNC_STAGES(SYNC), .ROW_W(ROWW), .SKIP_LINES(SKIP), .ACTIVE_LINES(ACT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_mark(line_mark),
    .half_flag_async(qsf), .xfer_req(xfer_req), .xfer_row(xfer_row),
    .xfer_half(xfer_half)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expect_issue(bit flag);
    return m_armed && (flag != m_last) && (m_line < SKIP + ACT);
  endfunction

  task automatic settle();
    repeat (SYNC + 1) @(negedge clk);
  endtask

  task automatic do_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    check("R7 no request after frame_start", xfer_req, 0);
    m_armed = 1'b1;
    m_line  = SKIP;
  endtask

  task automatic do_mark(string tag);
    bit e;
    int line_exp;
    e = expect_issue(qsf);
    line_exp = m_line;
    @(negedge clk); line_mark = 1'b1;
    @(negedge clk); line_mark = 1'b0;
    check(tag, xfer_req, int'(e));
    if (e) begin
      check("R6 row", xfer_row, line_exp >> 1);
      check("R6 half", xfer_half, line_exp & 1);
      m_last = qsf;
      m_line++;
    end
    @(negedge clk);
    check("R2 single-cycle pulse", xfer_req, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; frame_start = 1'b0; line_mark = 1'b0; qsf = 1'b0;
    m_armed = 1'b0; m_last = 1'b0; m_line = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset req", xfer_req, 0);
    check("R1 reset row", xfer_row, 0);
    check("R1 reset half", xfer_half, 0);

    // R1: flag moved, but block not armed yet
    qsf = 1'b1; settle();
    do_mark("R1 no request before frame_start");

    do_frame();
    // R3: flag 1 vs captured 0 -> transfer
    do_mark("R3 flag differs issues");
    // R4: same flag again -> nothing
    do_mark("R4 duplicate mark ignored");

    // R7: frame_start and mark together, flag changed
    qsf = 1'b0; settle();
    @(negedge clk); frame_start = 1'b1; line_mark = 1'b1;
    @(negedge clk); frame_start = 1'b0; line_mark = 1'b0;
    check("R7 mark with frame_start ignored", xfer_req, 0);
    m_line = SKIP;
    do_mark("R7 captured flag kept, next mark issues");

    // R5: marks at edges 1..3 after a flag change
    @(negedge clk); qsf = ~qsf; line_mark = 1'b1;
    @(negedge clk);
    check("R5 mark at edge 1 sees old flag", xfer_req, 0);
    @(negedge clk);
    check("R5 mark at edge 2 sees old flag", xfer_req, 0);
    @(negedge clk); line_mark = 1'b0;
    check("R5 mark at edge 3 sees new flag", xfer_req, 1);
    check("R6 row after sync", xfer_row, m_line >> 1);
    check("R6 half after sync", xfer_half, m_line & 1);
    m_last = qsf; m_line++;
    @(negedge clk);
    check("R2 single-cycle pulse", xfer_req, 0);

    // R8: run to end of frame
    for (int i = 0; i < ACT + 3; i++) begin
      qsf = ~qsf; settle();
      do_mark("R8 end of frame limit");
    end

    // mixed random run
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r == 0) do_frame();
      if ($urandom % 2 == 1) begin
        qsf = ~qsf; settle();
      end
      do_mark("R3 random candidate point");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule